// File: doc/BRIEF.md
# Two-Wire Bus Loopback Wiring Tester

This block decides, for each of a small set of two-wire serial buses (clock line and data line, open-drain), whether the pads the chip drives are really connected to the pads it reads back. A run is launched with a single-cycle start pulse. The ports are then visited one after another in ascending order. For every port the sequencer releases both lines and waits. It then issues a bus STOP so that any attached device is left idle. Two static line patterns follow, each with a readback comparison: clock pulled low with data released, then clock released with data pulled low. A port whose readback matches both patterns is marked as passing. It receives a closing STOP before the next port is visited.

All pauses are counted in ticks of a prescaled timebase, so the line toggling stays well inside standard-mode bus timing whatever the core clock. A configuration input chooses whether two or three ports are probed. At the end the block raises a one-cycle done pulse and presents a per-port pass vector and a flag that is set when at least one probed port passed. The block is meant to run once at bring-up, before any byte-level bus master is allowed to use the ports.

Top module: `ic_wiring_probe`

## Requirements
- R1: After reset `pass_o`, `any_pass_o` and `done_o` are 0, and every bit of `scl_low_o` and `sda_low_o` is 0. A 1 on these line outputs pulls that line low and a 0 releases it. A 1 on `scl_in_i`/`sda_in_i` reads the line as high.
- R2: A `start_i` pulse while idle begins a run and clears `pass_o` and `any_pass_o` in the next cycle. A `start_i` while a run is in progress has no effect on the result, the timing or the number of done pulses.
- R3: For each probed port, probe one expects clock read low and data read high while the clock is pulled low and data is released. Probe two expects clock read high and data read low while the clock is released and data is pulled low. The port's pass bit (bit index = port number) is set only when both readbacks match.
- R4: Ports are visited in ascending index order. At any time at most one port has a line pulled low, and all lines are released whenever no run is in progress.
- R5: `three_port_i`, sampled at start, selects three ports (0, 1, 2) when 1 and two ports (0, 1) when 0. In a two-port run port 2 is never driven and `pass_o[2]` stays 0.
- R6: When `done_o` is high, `any_pass_o` is 1 exactly when at least one probed port passed, and 0 otherwise.
- R7: `done_o` is high for exactly one cycle per run, after the last probed port has finished.
- R8: With D = `TICK_DIV`, a passing port takes 14+66·D cycles, a port failing probe one takes 8+36·D cycles, and a port failing probe two takes 11+45·D cycles. A failing port gets no closing STOP. `done_o` is first seen high the sum of these costs in cycles after the clock edge that accepted `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches a run when idle |
| three_port_i | input | 1 | 1: probe ports 0..2, 0: probe ports 0..1 |
| scl_in_i | input | NP | Clock line readback per port (1 = high) |
| sda_in_i | input | NP | Data line readback per port (1 = high) |
| scl_low_o | output | NP | Pull clock line of a port low |
| sda_low_o | output | NP | Pull data line of a port low |
| pass_o | output | NP | Per-port wiring pass flags |
| any_pass_o | output | 1 | At least one probed port passed |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
A step counter that skips or repeats a step changes the run length. The bench therefore compares the start-to-done distance against costs it sums from its own list of pauses, and any such slip shows up exactly at the done pulse. A wrong port index or a stale selection appears at once as two ports driven together, as port 2 being touched in a two-port run, or as a port visited out of order; a bench monitor catches these on the cycle they occur. A readback compared against the wrong level flips a pass bit, which is checked at done under loopback faults that each break only one of the two probes.

// File: rtl/ic_wt_pkg.sv
package ic_wt_pkg;

  // action applied to one line at step entry
  typedef enum logic [1:0] {
    LN_KEEP = 2'd0,
    LN_REL  = 2'd1,
    LN_LOW  = 2'd2
  } line_act_e;

  // readback comparison performed at step entry
  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_LOOP1 = 2'd1,
    CK_LOOP2 = 2'd2
  } chk_e;

  typedef struct packed {
    line_act_e scl;
    line_act_e sda;
    chk_e      chk;
    logic [3:0] wt;   // pause in ticks after the step's actions
  } step_t;

  localparam int unsigned STEP_W    = 4;
  localparam logic [3:0]  LAST_STEP = 4'd13;

  // per-port programme: STOP, probe one, probe two, closing STOP
  function automatic step_t step_rom(input logic [3:0] idx);
    step_t s;
    case (idx)
      4'd0:    s = '{LN_REL,  LN_REL,  CK_NONE,  4'd6};
      4'd1:    s = '{LN_KEEP, LN_LOW,  CK_NONE,  4'd3};
      4'd2:    s = '{LN_REL,  LN_KEEP, CK_NONE,  4'd9};
      4'd3:    s = '{LN_KEEP, LN_REL,  CK_NONE,  4'd6};
      4'd4:    s = '{LN_KEEP, LN_KEEP, CK_NONE,  4'd6};
      4'd5:    s = '{LN_LOW,  LN_KEEP, CK_NONE,  4'd3};
      4'd6:    s = '{LN_KEEP, LN_REL,  CK_NONE,  4'd3};
      4'd7:    s = '{LN_KEEP, LN_KEEP, CK_LOOP1, 4'd3};
      4'd8:    s = '{LN_REL,  LN_KEEP, CK_NONE,  4'd3};
      4'd9:    s = '{LN_KEEP, LN_LOW,  CK_NONE,  4'd3};
      4'd10:   s = '{LN_KEEP, LN_KEEP, CK_LOOP2, 4'd3};
      4'd11:   s = '{LN_KEEP, LN_LOW,  CK_NONE,  4'd3};
      4'd12:   s = '{LN_REL,  LN_KEEP, CK_NONE,  4'd9};
      default: s = '{LN_KEEP, LN_REL,  CK_NONE,  4'd6};
    endcase
    return s;
  endfunction

  function automatic logic line_next(input line_act_e act, input logic cur);
    case (act)
      LN_REL:  return 1'b0;
      LN_LOW:  return 1'b1;
      default: return cur;
    endcase
  endfunction

  // probe expectations: (clock, data) readback
  function automatic logic probe1_match(input logic scl_rd, input logic sda_rd);
    return !scl_rd && sda_rd;
  endfunction

  function automatic logic probe2_match(input logic scl_rd, input logic sda_rd);
    return scl_rd && !sda_rd;
  endfunction

endpackage

// File: rtl/ic_wt_tick.sv
module ic_wt_tick #(
  parameter int unsigned TICK_DIV = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(TICK_DIV) + 1;
  localparam logic [CW-1:0] TOP = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (tick_o)     cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ic_wt_lines.sv
module ic_wt_lines #(
  parameter int unsigned NP = 3,
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [PW-1:0] sel_i,
  input  logic          scl_low_i,
  input  logic          sda_low_i,
  input  logic [NP-1:0] scl_in_i,
  input  logic [NP-1:0] sda_in_i,
  output logic [NP-1:0] scl_low_o,
  output logic [NP-1:0] sda_low_o,
  output logic          scl_seen_o,
  output logic          sda_seen_o
);
  for (genvar g = 0; g < NP; g++) begin : g_port
    assign scl_low_o[g] = scl_low_i && (sel_i == PW'(g));
    assign sda_low_o[g] = sda_low_i && (sel_i == PW'(g));
  end

  assign scl_seen_o = scl_in_i[sel_i];
  assign sda_seen_o = sda_in_i[sel_i];
endmodule

// File: rtl/ic_wt_seq.sv
module ic_wt_seq
  import ic_wt_pkg::*;
#(
  parameter int unsigned NP = 3,
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          three_port_i,
  input  logic          tick_i,
  input  logic          scl_seen_i,
  input  logic          sda_seen_i,
  output logic [PW-1:0] sel_o,
  output logic          scl_low_o,
  output logic          sda_low_o,
  output logic          restart_o,
  output logic          busy_o,
  output logic          start_go_o,
  output logic          run3_o,
  output logic [NP-1:0] pass_o,
  output logic          any_pass_o,
  output logic          done_o
);
  logic              busy_q, entry_q, scl_q, sda_q, ok_q, done_q;
  logic [STEP_W-1:0] step_q;
  logic [3:0]        wcnt_q;
  logic [PW-1:0]     port_q, last_q;
  logic [NP-1:0]     pass_q;
  step_t             st;
  logic              chk_fail, step_end, port_end;

  assign st         = step_rom(step_q);
  assign start_go_o = start_i && !busy_q;
  assign chk_fail   = busy_q && entry_q &&
                      (((st.chk == CK_LOOP1) && !probe1_match(scl_seen_i, sda_seen_i)) ||
                       ((st.chk == CK_LOOP2) && !probe2_match(scl_seen_i, sda_seen_i)));
  assign step_end   = busy_q && !entry_q && tick_i && (wcnt_q == 4'd1);
  assign port_end   = chk_fail || (step_end && (step_q == LAST_STEP));
  assign restart_o  = !busy_q || entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; entry_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
      ok_q <= 1'b0; done_q <= 1'b0; step_q <= '0; wcnt_q <= '0;
      port_q <= '0; last_q <= '0; pass_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          entry_q <= 1'b1;
          step_q  <= '0;
          port_q  <= '0;
          pass_q  <= '0;
          ok_q    <= 1'b0;
          last_q  <= three_port_i ? PW'(NP - 1) : PW'(NP - 2);
        end
      end else begin
        if (entry_q) begin
          entry_q <= 1'b0;
          scl_q   <= line_next(st.scl, scl_q);
          sda_q   <= line_next(st.sda, sda_q);
          wcnt_q  <= st.wt;
          if ((st.chk == CK_LOOP2) && !chk_fail) pass_q[port_q] <= 1'b1;
        end else if (tick_i && !step_end) begin
          wcnt_q <= wcnt_q - 1'b1;
        end
        if (port_end) begin
          scl_q <= 1'b0;
          sda_q <= 1'b0;
          if (port_q == last_q) begin
            busy_q  <= 1'b0;
            entry_q <= 1'b0;
            done_q  <= 1'b1;
            ok_q    <= |pass_q;
          end else begin
            port_q  <= port_q + 1'b1;
            step_q  <= '0;
            entry_q <= 1'b1;
          end
        end else if (step_end) begin
          step_q  <= step_q + 1'b1;
          entry_q <= 1'b1;
        end
      end
    end
  end

  assign sel_o      = port_q;
  assign scl_low_o  = scl_q;
  assign sda_low_o  = sda_q;
  assign busy_o     = busy_q;
  assign run3_o     = (last_q == PW'(NP - 1));
  assign pass_o     = pass_q;
  assign any_pass_o = ok_q;
  assign done_o     = done_q;
endmodule

// File: rtl/ic_wiring_probe.sv
module ic_wiring_probe #(
  parameter int unsigned NP       = 3,
  parameter int unsigned TICK_DIV = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          three_port_i,
  input  logic [NP-1:0] scl_in_i,
  input  logic [NP-1:0] sda_in_i,
  output logic [NP-1:0] scl_low_o,
  output logic [NP-1:0] sda_low_o,
  output logic [NP-1:0] pass_o,
  output logic          any_pass_o,
  output logic          done_o
);
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1;

  logic [PW-1:0] sel_w;
  logic scl_low_w, sda_low_w, scl_seen_w, sda_seen_w;
  logic tick_w, restart_w;
  // named internal events for the checker
  logic busy_w, start_go_w, run3_w;

  ic_wt_tick #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_w), .tick_o(tick_w)
  );

  ic_wt_seq #(.NP(NP)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .three_port_i(three_port_i),
    .tick_i(tick_w), .scl_seen_i(scl_seen_w), .sda_seen_i(sda_seen_w),
    .sel_o(sel_w), .scl_low_o(scl_low_w), .sda_low_o(sda_low_w),
    .restart_o(restart_w), .busy_o(busy_w), .start_go_o(start_go_w),
    .run3_o(run3_w), .pass_o(pass_o), .any_pass_o(any_pass_o), .done_o(done_o)
  );

  ic_wt_lines #(.NP(NP)) lines_i (
    .sel_i(sel_w), .scl_low_i(scl_low_w), .sda_low_i(sda_low_w),
    .scl_in_i(scl_in_i), .sda_in_i(sda_in_i),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .scl_seen_o(scl_seen_w), .sda_seen_o(sda_seen_w)
  );
endmodule

// File: rtl/ic_wiring_probe_chk.sv
module ic_wiring_probe_chk #(
  parameter int unsigned NP = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_w,
  input logic          start_go_w,
  input logic          run3_w,
  input logic [NP-1:0] scl_low_o,
  input logic [NP-1:0] sda_low_o,
  input logic [NP-1:0] pass_o,
  input logic          any_pass_o,
  input logic          done_o
);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(scl_low_o | sda_low_o));

  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> ((scl_low_o == '0) && (sda_low_o == '0)));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go_w |=> ((pass_o == '0) && !any_pass_o));

  // R5
  two_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !run3_w) |-> (!pass_o[NP-1] && !scl_low_o[NP-1] && !sda_low_o[NP-1]));

  // R6
  ok_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (any_pass_o == (pass_o != '0)));
endmodule

bind ic_wiring_probe ic_wiring_probe_chk #(.NP(NP)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_w(busy_w), .start_go_w(start_go_w),
  .run3_w(run3_w), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
  .pass_o(pass_o), .any_pass_o(any_pass_o), .done_o(done_o)
);

// File: tb/ic_wiring_probe_tb.sv
module ic_wiring_probe_tb_top;
  localparam int NP = 3;
  localparam int D  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic three = 1'b1;
  logic [NP-1:0] scl_in, sda_in, scl_low, sda_low, pass;
  logic any_pass, done;

  // loopback model per port: 0 wired, 1 both inputs stuck high, 2 data input open
  int mode [NP];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;
  int multi_drv = 0;
  int order_err = 0;
  int max_seen = 0;
  logic [NP-1:0] seen;

  always #5 clk = ~clk;

  ic_wiring_probe #(.NP(NP), .TICK_DIV(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .three_port_i(three),
    .scl_in_i(scl_in), .sda_in_i(sda_in), .scl_low_o(scl_low), .sda_low_o(sda_low),
    .pass_o(pass), .any_pass_o(any_pass), .done_o(done)
  );

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      scl_in[i] = (mode[i] == 1) ? 1'b1 : !scl_low[i];
      sda_in[i] = (mode[i] != 0) ? 1'b1 : !sda_low[i];
    end
  end

  // line monitor
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
    if ($countones(scl_low | sda_low) > 1) multi_drv <= multi_drv + 1;
    for (int i = 0; i < NP; i++) begin
      if (scl_low[i] || sda_low[i]) begin
        seen[i] = 1'b1;
        if (i < max_seen) order_err <= order_err + 1;
        if (i > max_seen) max_seen <= i;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bench restatement of the per-port pause list (ticks)
  function automatic int port_cost(input int m);
    int w [14] = '{6, 3, 9, 6, 6, 3, 3, 3, 3, 3, 3, 3, 9, 6};
    int n_steps;
    int c = 0;
    n_steps = (m == 0) ? 14 : (m == 1) ? 7 : 10;
    for (int k = 0; k < n_steps; k++) c += 1 + w[k] * D;
    if (m != 0) c += 1;
    return c;
  endfunction

  task automatic run_case(input string name, input bit cfg3, input int m0, input int m1,
                          input int m2, input int restart_at);
    int np, n, exp_cyc;
    logic [NP-1:0] exp_pass;
    mode[0] = m0; mode[1] = m1; mode[2] = m2;
    np = cfg3 ? 3 : 2;
    exp_pass = '0;
    exp_cyc = 0;
    for (int i = 0; i < np; i++) begin
      exp_pass[i] = (mode[i] == 0);
      exp_cyc += port_cost(mode[i]);
    end
    @(negedge clk);
    three = cfg3;
    start = 1'b1;
    done_cnt = 0; multi_drv = 0; order_err = 0; max_seen = 0; seen = '0;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (n == 1) check(pass == '0 && !any_pass, {"R2 clear ", name}, int'(pass), 0);
      if (n == restart_at) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check(n < 20000, {"R7 done reached ", name}, n, exp_cyc);
    check(n == exp_cyc, {"R8 run length ", name}, n, exp_cyc);
    check(pass == exp_pass, {"R3 pass vector ", name}, int'(pass), int'(exp_pass));
    check(any_pass == (exp_pass != '0), {"R6 any pass ", name}, int'(any_pass),
          int'(exp_pass != '0));
    check(scl_low == '0 && sda_low == '0, {"R4 released at done ", name},
          int'({scl_low, sda_low}), 0);
    check(multi_drv == 0 && order_err == 0, {"R4 one port ascending ", name},
          multi_drv + order_err, 0);
    if (!cfg3) check(seen[2] == 1'b0 && pass[2] == 1'b0, {"R5 port 2 untouched ", name},
                     int'(seen[2]), 0);
    else check(seen == 3'b111, {"R5 three ports visited ", name}, int'(seen), 7);
    repeat (3) @(negedge clk);
    check(done_cnt == 1, {"R7 single done ", name}, done_cnt, 1);
    check(pass == exp_pass, {"R3 result held ", name}, int'(pass), int'(exp_pass));
  endtask

  task automatic reset_test();
    rst_n = 1'b0;
    mode[0] = 0; mode[1] = 0; mode[2] = 0;
    repeat (3) @(negedge clk);
    check(pass == '0 && !any_pass && !done, "R1 reset outputs", int'(pass), 0);
    check(scl_low == '0 && sda_low == '0, "R1 reset lines", int'({scl_low, sda_low}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(scl_low == '0 && sda_low == '0 && !done, "R1 idle after reset",
          int'({scl_low, sda_low}), 0);
  endtask

  initial begin
    reset_test();
    run_case("all wired x3", 1'b1, 0, 0, 0, 0);
    run_case("all wired x2", 1'b0, 0, 0, 0, 0);
    run_case("mixed faults", 1'b1, 1, 2, 0, 0);
    run_case("all broken", 1'b1, 2, 1, 1, 0);
    run_case("probe2 fail last", 1'b1, 0, 1, 2, 0);
    run_case("two port port2 bad", 1'b0, 2, 0, 1, 0);
    run_case("start while busy", 1'b1, 0, 2, 0, 300);
    run_case("all broken x2", 1'b0, 1, 1, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule